// File: doc/BRIEF.md
# Deep Sleep Power-State Controller

This controller decides when a small microcontroller may drop into its deepest power state and how it comes back out. Firmware arms entry with a write of the enable bit, and the very next executed instruction has to be the sleep instruction. The regulator-sleep bit must be set and the idle-enable bit clear at that moment. If those conditions do not all hold, the sleep instruction is treated as an ordinary sleep and a one-cycle light-sleep request is issued. During deep sleep the block holds a power-down request and keeps the I/O held.

Six events can end deep sleep: a watchdog timeout, a real-time clock alarm, an external interrupt, a low-power wake pin, the always-on fault monitor, and a brown-out trip when brown-out detection is enabled. Any of them starts a power-on reset pulse of fixed length, after which execution restarts from the reset vector. The cause of the wake, a brown-out flag, a deep-sleep-exit flag, the I/O hold and two context words all live in the retained domain and survive that reset. Only a true cold power-up, applied on `rst`, clears the flags and the hold. Firmware can also poll a registered copy of the clock-synchronisation busy flag before it arms entry.

Top module: `dsleep_ctrl`

## Requirements
- R1: With `regslp`=1 and `idle_en`=0, an instruction with `ds_arm_wr` followed by the next executed instruction (`instr_vld`=1) being `instr_sleep` raises `pdown_req` and `io_hold` on the following clock edge. Cycles with `instr_vld`=0 between the two instructions do not cancel the arming.
- R2: Any executed instruction between the arming write and the sleep instruction cancels the arming. The sleep instruction then produces a single-cycle `light_sleep_req` and `pdown_req` stays low.
- R3: When the sleep instruction follows an arming write but `regslp`=0 or `idle_en`=1, the result is `light_sleep_req` and no deep sleep.
- R4: A wake ends `pdown_req` on the next edge and drives `por_req` high for exactly POR_CYC cycles, after which the block returns to run.
- R5: `wake_flags` bit 0 = watchdog, bit 1 = clock alarm, bit 2 = external interrupt, bit 3 = low-power pin, bit 4 = fault monitor. Every source active in the first wake cycle is latched together. Sources that assert after the wake has started are ignored. The flags are cleared on deep-sleep entry and otherwise hold.
- R6: A fault-monitor input during deep sleep always wakes the device and sets bit 4.
- R7: A `bor_trip` during deep sleep with `bor_en`=1 wakes the device and sets `bor_flag`. With `bor_en`=0 the trip has no effect and the device stays asleep.
- R8: `ds_exit` is set on every wake and persists until `clr_exit` is applied while running. A clear applied while asleep has no effect.
- R9: The context words load from `ctx_wdata` only while running. They keep their contents through deep sleep and the wake reset, and writes attempted while asleep are ignored.
- R10: `io_hold` stays high from entry until `clr_release` is applied while running. A clear applied during the wake reset has no effect.
- R11: `rtc_busy` presents `rtc_busy_in` delayed by one clock.
- R12: Cold reset (`rst`) clears `pdown_req`, `por_req`, `light_sleep_req`, `ds_exit`, `wake_flags`, `bor_flag` and `io_hold`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Retained-domain clock |
| rst | input | 1 | Cold power-up reset, synchronous, active high |
| instr_vld | input | 1 | An instruction completes this cycle |
| instr_sleep | input | 1 | The completing instruction is the sleep instruction |
| ds_arm_wr | input | 1 | The completing instruction writes the deep-sleep enable bit |
| regslp | input | 1 | Regulator-sleep bit |
| idle_en | input | 1 | Idle-enable bit |
| ctx_wr | input | CTX_WORDS | Per-word context write strobe |
| ctx_wdata | input | W | Context write data |
| clr_exit | input | 1 | Software clear of the exit flag |
| clr_release | input | 1 | Software release of the I/O hold |
| bor_en | input | 1 | Deep-sleep brown-out detection enable |
| wk_wdt | input | 1 | Deep-sleep watchdog timeout |
| wk_rtc | input | 1 | Real-time clock alarm |
| wk_int0 | input | 1 | External interrupt |
| wk_ulp | input | 1 | Ultra-low-power wake pin |
| bor_trip | input | 1 | Brown-out detector trip |
| fault_det | input | 1 | Internal fault monitor |
| rtc_busy_in | input | 1 | Clock synchronisation busy flag |
| pdown_req | output | 1 | Power-down request, high in deep sleep |
| por_req | output | 1 | Power-on reset request after wake |
| light_sleep_req | output | 1 | One-cycle ordinary sleep request |
| ds_exit | output | 1 | Device left deep sleep |
| wake_flags | output | 5 | Latched wake causes |
| bor_flag | output | 1 | Brown-out occurred during deep sleep |
| io_hold | output | 1 | I/O state held |
| ctx_rdata | output | CTX_WORDS*W | Retained context words, word 0 in the low bits |
| rtc_busy | output | 1 | Registered synchronisation busy flag |

## Verification
The assertions assume that an instruction never carries both `ds_arm_wr` and `instr_sleep`, and that `rst` is held for at least one edge before the first checked cycle. The bench drives only one kind of instruction per cycle and changes inputs just after each rising edge. It sweeps all 128 combinations of the five wake inputs, the brown-out trip and its enable. A combination with no effective wake source is checked for staying asleep and is then woken by the watchdog.

// File: rtl/dsleep_pkg.sv
package dsleep_pkg;
  localparam int NWAKE    = 5;
  localparam int WK_WDT   = 0;
  localparam int WK_RTC   = 1;
  localparam int WK_INT   = 2;
  localparam int WK_ULP   = 3;
  localparam int WK_FAULT = 4;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_DSLEEP = 2'd1,
    ST_WAKE   = 2'd2
  } pstate_t;
endpackage

// File: rtl/dsleep_arm.sv
module dsleep_arm (
  input  logic clk,
  input  logic rst,
  input  logic in_run,
  input  logic instr_vld,
  input  logic instr_sleep,
  input  logic ds_arm_wr,
  input  logic regslp,
  input  logic idle_en,
  input  logic rtc_busy_in,
  output logic go_deep,
  output logic light_sleep_req,
  output logic rtc_busy
);
  logic arm_q;
  logic light_q;
  logic busy_q;

  // Deep entry needs the armed bit from the directly preceding instruction
  assign go_deep = in_run && instr_vld && instr_sleep && arm_q && regslp && !idle_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q   <= 1'b0;
      light_q <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      busy_q  <= rtc_busy_in;
      light_q <= in_run && instr_vld && instr_sleep && !go_deep;
      if (!in_run)        arm_q <= 1'b0;
      else if (instr_vld) arm_q <= ds_arm_wr;
    end
  end

  assign light_sleep_req = light_q;
  assign rtc_busy        = busy_q;

  // R2: an ordinary sleep request is only issued while running
  p_light_in_run_r2: assert property (@(posedge clk) disable iff (rst)
    light_q |-> in_run);
  // R11: busy flag mirrors its input one cycle later
  p_busy_delay_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (busy_q == $past(rtc_busy_in)));
endmodule

// File: rtl/dsleep_seq.sv
module dsleep_seq
  import dsleep_pkg::*;
#(
  parameter int POR_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic go_deep,
  input  logic wake_any,
  output logic in_run,
  output logic in_ds,
  output logic wake_start,
  output logic pdown_req,
  output logic por_req
);
  localparam int CW = $clog2(POR_CYC + 1);

  pstate_t       state_q;
  logic [CW-1:0] cnt_q;
  logic          pdown_q;
  logic          por_q;

  assign in_run     = (state_q == ST_RUN);
  assign in_ds      = (state_q == ST_DSLEEP);
  assign wake_start = in_ds && wake_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
      pdown_q <= 1'b0;
      por_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (go_deep) begin
            state_q <= ST_DSLEEP;
            pdown_q <= 1'b1;
          end
        end
        ST_DSLEEP: begin
          if (wake_any) begin
            state_q <= ST_WAKE;
            pdown_q <= 1'b0;
            por_q   <= 1'b1;
            cnt_q   <= CW'(POR_CYC - 1);
          end
        end
        ST_WAKE: begin
          if (cnt_q == '0) begin
            state_q <= ST_RUN;
            por_q   <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign pdown_req = pdown_q;
  assign por_req   = por_q;

  // R1: power-down begins only right after a qualified entry
  p_pdown_entry_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(pdown_q) |-> $past(go_deep));
  // R4: leaving power-down always raises the reset request
  p_exit_por_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(pdown_q) |-> por_q);
  // R4: reset request only follows power-down
  p_por_src_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(por_q) |-> $past(pdown_q));
  // R4: the two requests never overlap
  p_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(pdown_q && por_q));
endmodule

// File: rtl/dsleep_wake.sv
module dsleep_wake
  import dsleep_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_ds,
  input  logic             go_deep,
  input  logic             wake_start,
  input  logic             bor_en,
  input  logic             wk_wdt,
  input  logic             wk_rtc,
  input  logic             wk_int0,
  input  logic             wk_ulp,
  input  logic             bor_trip,
  input  logic             fault_det,
  output logic             wake_any,
  output logic [NWAKE-1:0] wake_flags,
  output logic             bor_flag
);
  logic [NWAKE-1:0] vec;
  logic             bor_hit;
  logic [NWAKE-1:0] flags_q;
  logic             bor_q;

  always_comb begin
    vec           = '0;
    vec[WK_WDT]   = wk_wdt;
    vec[WK_RTC]   = wk_rtc;
    vec[WK_INT]   = wk_int0;
    vec[WK_ULP]   = wk_ulp;
    vec[WK_FAULT] = fault_det;
  end

  assign bor_hit  = bor_en && bor_trip;
  assign wake_any = (|vec) || bor_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      bor_q   <= 1'b0;
    end else if (go_deep) begin
      flags_q <= '0;
      bor_q   <= 1'b0;
    end else if (wake_start) begin
      flags_q <= vec;
      bor_q   <= bor_hit;
    end
  end

  assign wake_flags = flags_q;
  assign bor_flag   = bor_q;

  // R6: the fault monitor always records its flag while asleep
  p_fault_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (in_ds && fault_det) |=> flags_q[WK_FAULT]);
  // R5: flags move only on entry or on the first wake cycle
  p_flags_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!wake_start && !go_deep) |=> ($stable(flags_q) && $stable(bor_q)));
  // R7: a disabled detector never sets the brown-out flag
  p_bor_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (in_ds && !bor_en) |=> !bor_q);
endmodule

// File: rtl/dsleep_retain.sv
module dsleep_retain #(
  parameter int W         = 8,
  parameter int CTX_WORDS = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_run,
  input  logic                   in_ds,
  input  logic                   go_deep,
  input  logic                   wake_start,
  input  logic                   clr_exit,
  input  logic                   clr_release,
  input  logic [CTX_WORDS-1:0]   ctx_wr,
  input  logic [W-1:0]           ctx_wdata,
  output logic                   ds_exit,
  output logic                   io_hold,
  output logic [CTX_WORDS*W-1:0] ctx_rdata
);
  logic exit_q;
  logic hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      exit_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (wake_start)              exit_q <= 1'b1;
      else if (in_run && clr_exit) exit_q <= 1'b0;
      if (go_deep)                    hold_q <= 1'b1;
      else if (in_run && clr_release) hold_q <= 1'b0;
    end
  end

  // Retained words are deliberately left out of the cold reset
  for (genvar gi = 0; gi < CTX_WORDS; gi++) begin : g_ctx
    logic [W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (in_run && ctx_wr[gi]) word_q <= ctx_wdata;
    end
    assign ctx_rdata[gi*W +: W] = word_q;
  end

  assign ds_exit = exit_q;
  assign io_hold = hold_q;

  // R10: I/O is held throughout deep sleep
  p_hold_in_ds_r10: assert property (@(posedge clk) disable iff (rst)
    in_ds |-> hold_q);
  // R8: every wake sets the exit flag
  p_exit_set_r8: assert property (@(posedge clk) disable iff (rst)
    wake_start |=> exit_q);
  // R9: context words are frozen outside run
  p_ctx_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    !in_run |=> $stable(ctx_rdata));
endmodule

// File: rtl/dsleep_ctrl.sv
module dsleep_ctrl
  import dsleep_pkg::*;
#(
  parameter int W         = 8,
  parameter int CTX_WORDS = 2,
  parameter int POR_CYC   = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   instr_vld,
  input  logic                   instr_sleep,
  input  logic                   ds_arm_wr,
  input  logic                   regslp,
  input  logic                   idle_en,
  input  logic [CTX_WORDS-1:0]   ctx_wr,
  input  logic [W-1:0]           ctx_wdata,
  input  logic                   clr_exit,
  input  logic                   clr_release,
  input  logic                   bor_en,
  input  logic                   wk_wdt,
  input  logic                   wk_rtc,
  input  logic                   wk_int0,
  input  logic                   wk_ulp,
  input  logic                   bor_trip,
  input  logic                   fault_det,
  input  logic                   rtc_busy_in,
  output logic                   pdown_req,
  output logic                   por_req,
  output logic                   light_sleep_req,
  output logic                   ds_exit,
  output logic [NWAKE-1:0]       wake_flags,
  output logic                   bor_flag,
  output logic                   io_hold,
  output logic [CTX_WORDS*W-1:0] ctx_rdata,
  output logic                   rtc_busy
);
  logic in_run;
  logic in_ds;
  logic go_deep;
  logic wake_any;
  logic wake_start;

  dsleep_arm u_arm (
    .clk(clk), .rst(rst), .in_run(in_run),
    .instr_vld(instr_vld), .instr_sleep(instr_sleep), .ds_arm_wr(ds_arm_wr),
    .regslp(regslp), .idle_en(idle_en), .rtc_busy_in(rtc_busy_in),
    .go_deep(go_deep), .light_sleep_req(light_sleep_req), .rtc_busy(rtc_busy)
  );

  dsleep_seq #(.POR_CYC(POR_CYC)) u_seq (
    .clk(clk), .rst(rst), .go_deep(go_deep), .wake_any(wake_any),
    .in_run(in_run), .in_ds(in_ds), .wake_start(wake_start),
    .pdown_req(pdown_req), .por_req(por_req)
  );

  dsleep_wake u_wake (
    .clk(clk), .rst(rst), .in_ds(in_ds), .go_deep(go_deep),
    .wake_start(wake_start), .bor_en(bor_en),
    .wk_wdt(wk_wdt), .wk_rtc(wk_rtc), .wk_int0(wk_int0), .wk_ulp(wk_ulp),
    .bor_trip(bor_trip), .fault_det(fault_det),
    .wake_any(wake_any), .wake_flags(wake_flags), .bor_flag(bor_flag)
  );

  dsleep_retain #(.W(W), .CTX_WORDS(CTX_WORDS)) u_retain (
    .clk(clk), .rst(rst), .in_run(in_run), .in_ds(in_ds),
    .go_deep(go_deep), .wake_start(wake_start),
    .clr_exit(clr_exit), .clr_release(clr_release),
    .ctx_wr(ctx_wr), .ctx_wdata(ctx_wdata),
    .ds_exit(ds_exit), .io_hold(io_hold), .ctx_rdata(ctx_rdata)
  );
endmodule

// File: tb/dsleep_ctrl_tb_top.sv
module dsleep_ctrl_tb_top;
  localparam int W = 8;
  localparam int CW = 2;
  localparam int P = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic instr_vld = 0, instr_sleep = 0, ds_arm_wr = 0, regslp = 1, idle_en = 0;
  logic [CW-1:0] ctx_wr = '0;
  logic [W-1:0]  ctx_wdata = '0;
  logic clr_exit = 0, clr_release = 0, bor_en = 0;
  logic wk_wdt = 0, wk_rtc = 0, wk_int0 = 0, wk_ulp = 0, bor_trip = 0, fault_det = 0;
  logic rtc_busy_in = 0;
  logic pdown_req, por_req, light_sleep_req, ds_exit, bor_flag, io_hold, rtc_busy;
  logic [4:0] wake_flags;
  logic [CW*W-1:0] ctx_rdata;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  dsleep_ctrl #(.W(W), .CTX_WORDS(CW), .POR_CYC(P)) dut_i (
    .clk(clk), .rst(rst), .instr_vld(instr_vld), .instr_sleep(instr_sleep),
    .ds_arm_wr(ds_arm_wr), .regslp(regslp), .idle_en(idle_en),
    .ctx_wr(ctx_wr), .ctx_wdata(ctx_wdata), .clr_exit(clr_exit),
    .clr_release(clr_release), .bor_en(bor_en), .wk_wdt(wk_wdt), .wk_rtc(wk_rtc),
    .wk_int0(wk_int0), .wk_ulp(wk_ulp), .bor_trip(bor_trip), .fault_det(fault_det),
    .rtc_busy_in(rtc_busy_in), .pdown_req(pdown_req), .por_req(por_req),
    .light_sleep_req(light_sleep_req), .ds_exit(ds_exit), .wake_flags(wake_flags),
    .bor_flag(bor_flag), .io_hold(io_hold), .ctx_rdata(ctx_rdata), .rtc_busy(rtc_busy)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_wake(input logic [4:0] v, input logic b);
    wk_wdt = v[0]; wk_rtc = v[1]; wk_int0 = v[2]; wk_ulp = v[3]; fault_det = v[4];
    bor_trip = b;
  endtask

  task automatic instr(input logic arm, input logic slp);
    instr_vld = 1'b1; ds_arm_wr = arm; instr_sleep = slp;
    tick();
    instr_vld = 1'b0; ds_arm_wr = 1'b0; instr_sleep = 1'b0;
  endtask

  task automatic enter_deep();
    instr(1'b1, 1'b0);
    instr(1'b0, 1'b1);
    chk("R1 pdown", {31'd0, pdown_req}, 32'd1);
    chk("R1 hold", {31'd0, io_hold}, 32'd1);
  endtask

  initial begin
    tick(); tick();
    rst = 1'b0;
    chk("R12 pdown", {31'd0, pdown_req}, 0);
    chk("R12 por", {31'd0, por_req}, 0);
    chk("R12 flags", {27'd0, wake_flags}, 0);
    chk("R12 exit/bor/hold", {29'd0, ds_exit, bor_flag, io_hold}, 0);

    rtc_busy_in = 1; tick(); chk("R11 busy", {31'd0, rtc_busy}, 1);
    rtc_busy_in = 0; tick(); chk("R11 idle", {31'd0, rtc_busy}, 0);

    ctx_wr = 2'b01; ctx_wdata = 8'h5A; tick();
    ctx_wr = 2'b10; ctx_wdata = 8'hC3; tick(); ctx_wr = '0;
    chk("R9 ctx load", {16'd0, ctx_rdata}, 32'hC35A);

    // R2: an instruction between arm and sleep cancels the arming
    instr(1'b1, 1'b0); instr(1'b0, 1'b0); instr(1'b0, 1'b1);
    chk("R2 light", {31'd0, light_sleep_req}, 1);
    chk("R2 no deep", {31'd0, pdown_req}, 0);
    tick(); chk("R2 pulse", {31'd0, light_sleep_req}, 0);

    // R3: regulator-sleep clear, then idle-enable set
    regslp = 0; instr(1'b1, 1'b0); instr(1'b0, 1'b1);
    chk("R3 regslp light", {31'd0, light_sleep_req}, 1);
    chk("R3 regslp no deep", {31'd0, pdown_req}, 0);
    regslp = 1; idle_en = 1; instr(1'b1, 1'b0); instr(1'b0, 1'b1);
    chk("R3 idle light", {31'd0, light_sleep_req}, 1);
    chk("R3 idle no deep", {31'd0, pdown_req}, 0);
    idle_en = 0; tick();

    // R1: idle bus cycles between arm and sleep keep it armed
    instr(1'b1, 1'b0); tick(); tick(); instr(1'b0, 1'b1);
    chk("R1 gap deep", {31'd0, pdown_req}, 1);
    chk("R1 no light", {31'd0, light_sleep_req}, 0);
    set_wake(5'b00001, 0); tick(); set_wake(5'b0, 0);
    for (int k = 0; k < P; k++) tick();
    clr_release = 1; clr_exit = 1; tick(); clr_release = 0; clr_exit = 0;

    // Sweep all wake input combinations with the brown-out enable
    for (int c = 0; c < 128; c++) begin
      logic [4:0] v;
      logic       b, be, eff_b;
      logic [7:0] tag;
      v = c[4:0]; b = c[5]; be = c[6]; eff_b = b & be;
      tag = 8'(c);
      bor_en = be;
      ctx_wr = 2'b11; ctx_wdata = tag; tick(); ctx_wr = '0;
      enter_deep();
      chk("R5 flags clear on entry", {27'd0, wake_flags}, 0);
      // writes and clears attempted while asleep
      ctx_wr = 2'b01; ctx_wdata = ~tag; clr_exit = 1; clr_release = 1;
      instr(1'b0, 1'b0);
      ctx_wr = '0; clr_exit = 0; clr_release = 0;
      chk("R10 hold kept asleep", {31'd0, io_hold}, 1);
      set_wake(v, b);
      if (v == 0 && !eff_b) begin
        tick();
        chk("R7 bor disabled stays asleep", {31'd0, pdown_req}, 1);
        chk("R7 no bor flag", {31'd0, bor_flag}, 0);
        set_wake(5'b00001, b);
        v = 5'b00001;
      end
      tick();
      set_wake(5'b0, 0);
      chk("R5 flags", {27'd0, wake_flags}, {27'd0, v});
      chk("R7 bor flag", {31'd0, bor_flag}, {31'd0, eff_b});
      if (v[4]) chk("R6 fault flag", {31'd0, wake_flags[4]}, 1);
      chk("R4 pdown off", {31'd0, pdown_req}, 0);
      chk("R4 por on", {31'd0, por_req}, 1);
      chk("R8 exit set", {31'd0, ds_exit}, 1);
      // late wake sources and clears during the reset pulse
      set_wake(~v, 1'b1); clr_release = 1; clr_exit = 1;
      for (int k = 1; k < P; k++) begin
        tick();
        chk("R4 por held", {31'd0, por_req}, 1);
      end
      set_wake(5'b0, 0); clr_release = 0; clr_exit = 0;
      chk("R5 late ignored", {27'd0, wake_flags}, {27'd0, v});
      chk("R10 hold during por", {31'd0, io_hold}, 1);
      tick();
      chk("R4 por end", {31'd0, por_req}, 0);
      chk("R8 exit persists", {31'd0, ds_exit}, 1);
      chk("R9 ctx retained", {16'd0, ctx_rdata}, {16'd0, tag, tag});
      clr_exit = 1; tick(); clr_exit = 0;
      chk("R8 exit cleared", {31'd0, ds_exit}, 0);
      chk("R10 hold before release", {31'd0, io_hold}, 1);
      clr_release = 1; tick(); clr_release = 0;
      chk("R10 released", {31'd0, io_hold}, 0);
      chk("R5 flags persist in run", {27'd0, wake_flags}, {27'd0, v});
    end

    // R12: cold reset after a wake clears the retained status
    bor_en = 1;
    enter_deep();
    set_wake(5'b10000, 1); tick(); set_wake(5'b0, 0);
    rst = 1; tick(); rst = 0;
    chk("R12 flags", {27'd0, wake_flags}, 0);
    chk("R12 exit/bor/hold", {29'd0, ds_exit, bor_flag, io_hold}, 0);
    chk("R12 por/pdown", {30'd0, por_req, pdown_req}, 0);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule